// File: doc/BRIEF.md
# Dual-Mode Operating-System Timer Channel

This block is one timer channel for an operating-system tick or timekeeping service. It holds a counter, a compare register and a one-bit mode selector behind a small synchronous register bus. The channel is armed by a write to a start trigger register, disarmed by a write to a separate stop trigger register, and a read-only status bit shows whether it is running. The counter advances only on clock cycles where the `tick` input is high. A prescaler outside the block drives `tick`.

In interval mode the counter is loaded from the compare register when the channel starts and then counts down. Each time it passes zero it raises a one-cycle interrupt and reloads, so a compare value N gives one interrupt every N+1 ticks. In free-running mode the counter clears at start and counts up through its whole range. It raises an interrupt when it lands on a non-zero compare value, so a compare value of zero gives a pure timekeeping counter. Compare and mode are programmed while the channel is stopped. Read data is registered and returns the state as it was before the clock edge that samples the address.

Top module: `ostimer_chan`

## Requirements
- R1: After reset the compare, counter, status and control registers all read 0 and `irq` is low.
- R2: Compare (offset 0x00) is written per byte lane under `bus_be` and reads back what was written. Control (offset 0x20) stores only bit 1, the mode (0 = interval, 1 = free-running), and all of its other bits read 0.
- R3: A write to offset 0x14 with lane 0 enabled and data bit 0 = 1 starts a stopped channel, and status bit 0 (offset 0x10) then reads 1. A write there with data bit 0 = 0 has no effect.
- R4: A write to offset 0x18 with lane 0 enabled and data bit 0 = 1 stops the channel. Status then reads 0 and the counter freezes at its value, whatever `tick` does. A stop written while the channel is already stopped changes nothing.
- R5: In interval mode the counter loads the compare value N at start and decrements once per tick. The tick that finds it at 0 reloads N and pulses `irq` high for one cycle, so interrupts repeat every N+1 ticks.
- R6: In free-running mode the counter clears to 0 at start, adds 1 per tick, and wraps from 2^CNT_W-1 to 0.
- R7: In free-running mode `irq` pulses for one cycle on the tick that makes the counter equal a non-zero compare value. A compare value of 0 never raises `irq`.
- R8: Writes to compare or control while the channel runs are ignored.
- R9: A running counter holds its value on cycles where `tick` is low.
- R10: A stop trigger in the same cycle as a tick wins. The tick is discarded, the counter keeps its value and no interrupt is raised, even when that tick would have ended a period.
- R11: A start trigger written while the channel runs is ignored, and the counter is not reloaded.
- R12: The counter register (offset 0x04) ignores writes. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_be | input | DATA_W/8 | Byte lane enables for a write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| tick | input | 1 | Count enable, one count per high cycle |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A stop trigger and a tick can arrive in the same cycle. The hardest case is when that tick would end an interval period and so reload the counter and raise the interrupt. The bench runs an interval channel down to zero, then drives the stop write and `tick` in the same cycle. It expects `irq` to stay low, the counter to read 0 rather than the compare value, and the status to read 0. A second pairing, a start trigger to a channel that is already running, is judged by whether the counter value survives unchanged.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  typedef enum logic [0:0] {
    MODE_INTERVAL = 1'b0,
    MODE_FREERUN  = 1'b1
  } mode_t;

  localparam int OFF_CMP    = 'h00;
  localparam int OFF_CNT    = 'h04;
  localparam int OFF_STATUS = 'h10;
  localparam int OFF_START  = 'h14;
  localparam int OFF_STOP   = 'h18;
  localparam int OFF_CTRL   = 'h20;
endpackage

// File: rtl/ostmr_regs.sv
module ostmr_regs
  import ostmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                run_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [CNT_W-1:0]    cmp_o,
  output mode_t               mode_o,
  output logic                start_o,
  output logic                stop_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] A_CMP    = ADDR_W'(OFF_CMP);
  localparam logic [ADDR_W-1:0] A_CNT    = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_STOP   = ADDR_W'(OFF_STOP);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

  logic [CNT_W-1:0]  cmp_q;
  mode_t             mode_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] cmp_merge;
  logic              cfg_open;

  // configuration is writable only while the channel is stopped
  assign cfg_open = wr_i && !run_i;

  always_comb begin
    cmp_merge = DATA_W'(cmp_q);
    for (int b = 0; b < LANES; b++) begin
      if (be_i[b]) cmp_merge[b*8 +: 8] = wdata_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= MODE_INTERVAL;
    end else if (cfg_open) begin
      if (addr_i == A_CMP)              cmp_q  <= cmp_merge[CNT_W-1:0];
      if (addr_i == A_CTRL && be_i[0])  mode_q <= mode_t'(wdata_i[1]);
    end
  end

  assign start_o = wr_i && addr_i == A_START && be_i[0] && wdata_i[0];
  assign stop_o  = wr_i && addr_i == A_STOP  && be_i[0] && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (addr_i)
        A_CMP:    rdata_q <= DATA_W'(cmp_q);
        A_CNT:    rdata_q <= DATA_W'(cnt_i);
        A_STATUS: rdata_q <= DATA_W'(run_i);
        A_CTRL:   rdata_q <= DATA_W'({mode_q, 1'b0});
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign cmp_o   = cmp_q;
  assign mode_o  = mode_q;

  // R8: configuration frozen while running
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (rst)
    run_i |=> ($stable(cmp_q) && $stable(mode_q)));
endmodule

// File: rtl/ostmr_core.sv
module ostmr_core
  import ostmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  mode_t            mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             run_q;
  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_up;

  assign cnt_up = cnt_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= ZERO;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i && run_q) begin
        run_q <= 1'b0;                      // stop wins over a tick
      end else if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= (mode_i == MODE_FREERUN) ? ZERO : cmp_i;
      end else if (run_q && tick_i) begin
        if (mode_i == MODE_INTERVAL) begin
          if (cnt_q == ZERO) begin
            cnt_q <= cmp_i;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end else begin
          cnt_q <= cnt_up;
          if (cmp_i != ZERO && cnt_up == cmp_i) irq_q <= 1'b1;
        end
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R3: a start on an idle channel arms it
  p_start_arms_r3: assert property (@(posedge clk) disable iff (rst)
    (start_i && !run_q) |=> run_q);
  // R4: an idle channel keeps its count
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> ($stable(cnt_q) && !irq_q));
  // R5: terminal tick reloads and interrupts
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !stop_i && mode_i == MODE_INTERVAL && cnt_q == ZERO)
      |=> (irq_q && cnt_q == $past(cmp_i)));
  // R6: free-running step of one, wrapping at the width
  p_freerun_step_r6: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !stop_i && mode_i == MODE_FREERUN)
      |=> cnt_q == CNT_W'($past(cnt_q) + ONE));
  // R9: no tick, no change
  p_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick_i && !stop_i) |=> ($stable(cnt_q) && !irq_q));
  // R10: stop discards a coincident tick
  p_stop_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (run_q && stop_i) |=> (!run_q && !irq_q && $stable(cnt_q)));
endmodule

// File: rtl/ostimer_chan.sv
module ostimer_chan
  import ostmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                tick,
  output logic                irq
);
  logic             run;
  logic             start_req;
  logic             stop_req;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  mode_t            mode;

  ostmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .be_i    (bus_be),
    .wdata_i (bus_wdata),
    .run_i   (run),
    .cnt_i   (cnt),
    .rdata_o (bus_rdata),
    .cmp_o   (cmp),
    .mode_o  (mode),
    .start_o (start_req),
    .stop_o  (stop_req)
  );

  ostmr_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .start_i (start_req),
    .stop_i  (stop_req),
    .mode_i  (mode),
    .cmp_i   (cmp),
    .run_o   (run),
    .cnt_o   (cnt),
    .irq_o   (irq)
  );

  // R1: interrupt line quiet during reset release
  p_irq_needs_run_r1: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(run));
endmodule

// File: tb/sim_ostimer_chan.sv
module sim_ostimer_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        tick = 1'b0;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ostimer_chan u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .tick(tick), .irq(irq0));
  ostimer_chan #(.CNT_W(8)) u1 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .tick(tick), .irq(irq1));

  // vector: mode[80] cmp[79:48] ticks[47:40] exp_cnt[39:8] exp_irqs[7:0]
  localparam logic [80:0] VEC [8] = '{
    {1'b0, 32'd3,  8'd10, 32'd1,  8'd2},
    {1'b0, 32'd0,  8'd5,  32'd0,  8'd5},
    {1'b0, 32'd5,  8'd4,  32'd1,  8'd0},
    {1'b0, 32'd1,  8'd7,  32'd0,  8'd3},
    {1'b1, 32'd0,  8'd6,  32'd6,  8'd0},
    {1'b1, 32'd4,  8'd9,  32'd9,  8'd1},
    {1'b1, 32'd9,  8'd9,  32'd9,  8'd1},
    {1'b1, 32'd10, 8'd9,  32'd9,  8'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk); #1;
    d0 = rdata0; d1 = rdata1;
  endtask

  task automatic pulse_ticks(input int n, output int irqs);
    irqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (irq0) irqs++; tick = 1'b1;
      @(negedge clk); if (irq0) irqs++; tick = 1'b0;
    end
    @(negedge clk); if (irq0) irqs++;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h00, v, w); chk(v == 0, "R1 compare", v, 0);
    rd(6'h04, v, w); chk(v == 0, "R1 counter", v, 0);
    rd(6'h10, v, w); chk(v == 0, "R1 status", v, 0);
    rd(6'h20, v, w); chk(v == 0, "R1 control", v, 0);
    chk(irq0 == 0, "R1 irq", 32'(irq0), 0);

    // R2 byte lanes and control bit
    wr(6'h00, 32'h11223344, 4'b0101);
    rd(6'h00, v, w); chk(v == 32'h00220044, "R2 compare lanes", v, 32'h00220044);
    wr(6'h20, 32'hFF, 4'b0001);
    rd(6'h20, v, w); chk(v == 32'h2, "R2 control bits", v, 32'h2);
    wr(6'h20, 32'h0, 4'b0001);

    // R12 counter write ignored, unmapped read zero
    wr(6'h04, 32'hDEAD, 4'hF);
    rd(6'h04, v, w); chk(v == 0, "R12 counter write", v, 0);
    rd(6'h08, v, w); chk(v == 0, "R12 unmapped", v, 0);

    // R3 start with bit 0 clear is no-op
    wr(6'h14, 32'hFE, 4'b0001);
    rd(6'h10, v, w); chk(v == 0, "R3 start bit0 clear", v, 0);

    // vector table: R5 interval, R6/R7 free-running, R9 idle cycles between ticks
    foreach (VEC[k]) begin
      wr(6'h18, 32'h1, 4'b0001);
      wr(6'h00, VEC[k][79:48], 4'hF);
      wr(6'h20, {30'd0, VEC[k][80], 1'b0}, 4'b0001);
      wr(6'h14, 32'h1, 4'b0001);
      rd(6'h10, v, w); chk(v == 1, "R3 status running", v, 1);
      pulse_ticks(int'(VEC[k][47:40]), n);
      rd(6'h04, v, w);
      chk(v == VEC[k][39:8], VEC[k][80] ? "R6 free count" : "R5 interval count", v, VEC[k][39:8]);
      chk(n == int'(VEC[k][7:0]), VEC[k][80] ? "R7 irq count" : "R5 irq count", 32'(n), 32'(VEC[k][7:0]));
    end

    // R8 config locked while running (free-running, compare 10, still running)
    wr(6'h00, 32'h77, 4'hF);
    wr(6'h20, 32'h0, 4'b0001);
    rd(6'h00, v, w); chk(v == 32'd10, "R8 compare locked", v, 10);
    rd(6'h20, v, w); chk(v == 32'h2, "R8 control locked", v, 2);

    // R4 stop freezes, repeated stop no effect
    wr(6'h18, 32'h1, 4'b0001);
    pulse_ticks(3, n);
    rd(6'h04, v, w); chk(v == 32'd9, "R4 frozen count", v, 9);
    chk(n == 0, "R4 no irq when stopped", 32'(n), 0);
    wr(6'h18, 32'h1, 4'b0001);
    rd(6'h10, v, w); chk(v == 0, "R4 status stopped", v, 0);
    rd(6'h04, v, w); chk(v == 32'd9, "R4 second stop", v, 9);

    // R11 start while running ignored
    wr(6'h00, 32'd5, 4'hF);
    wr(6'h20, 32'h0, 4'b0001);
    wr(6'h14, 32'h1, 4'b0001);
    pulse_ticks(2, n);
    wr(6'h14, 32'h1, 4'b0001);
    rd(6'h04, v, w); chk(v == 32'd3, "R11 restart ignored", v, 3);

    // R10 stop coincident with terminal tick
    wr(6'h18, 32'h1, 4'b0001);
    wr(6'h00, 32'd2, 4'hF);
    wr(6'h14, 32'h1, 4'b0001);
    pulse_ticks(2, n);
    @(negedge clk);
    bus_addr = 6'h18; bus_wdata = 32'h1; bus_be = 4'b0001; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; tick = 1'b0;
    chk(irq0 == 0, "R10 no irq on stop", 32'(irq0), 0);
    rd(6'h04, v, w); chk(v == 0, "R10 count kept", v, 0);
    rd(6'h10, v, w); chk(v == 0, "R10 stopped", v, 0);

    // R6 wrap: 8-bit instance wraps at 256
    wr(6'h00, 32'h0, 4'hF);
    wr(6'h20, 32'h2, 4'b0001);
    wr(6'h14, 32'h1, 4'b0001);
    @(negedge clk); tick = 1'b1;
    repeat (259) @(posedge clk);
    @(negedge clk); tick = 1'b0;
    rd(6'h04, v, w);
    chk(w == 32'd3, "R6 wrap narrow", w, 3);
    chk(v == 32'd259, "R6 wide count", v, 259);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule